// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block sits between an 8-bit CPU and its memories. It maps the lower 32 KB of CPU address space (CPU address bit 15 low) onto either a 512 KB RAM or a 1 MB ROM/flash. Which device is used, and which 32 KB page of it, is set by two page latches. The CPU writes these latches with I/O write cycles. The CPU's low 15 address bits pass through unchanged as the offset inside the page. The upper bits of the physical address come from whichever latch is in charge.

The ROM page latch also holds the device select bit. The RAM page latch supplies only a RAM page number. The two latches are write-only. An I/O read of any of their ports returns all ones. A memory write to the ROM is dropped unless the board-level programming enable is high.

A small access state machine has two states, `ST_IDLE` and `ST_HOLD`. It freezes the page mapping for the length of each memory access:
- `start`: from `ST_IDLE` to `ST_HOLD` on the first cycle with a memory strobe high. The live mapping is captured on this transition.
- `finish`: from `ST_HOLD` to `ST_IDLE` when both strobes are low.
- `remain`: the state is kept in every other case.

While the state machine is in `ST_HOLD`, the captured mapping drives the outputs. In `ST_IDLE` the live latch contents drive them. A latch write therefore changes the mapping from the next memory access onward.

Top module: `bank_window_mapper`

## Requirements
- R1: After reset both latches hold 0x00, so a window read selects the ROM, and phys_addr[19:15] reads 0.
- R2: When ROM latch bit 7 is 1, a window access asserts ram_cs. phys_addr[18:15] then equals RAM latch bits 3:0, and phys_addr[19] is 0.
- R3: When ROM latch bit 7 is 0, a window read asserts rom_cs, and phys_addr[19:15] equals ROM latch bits 4:0.
- R4: Only ROM latch bit 7 selects the device. RAM latch bit 7 has no effect on the selection.
- R5: Port decode uses only io_port[4:0]. Writes to 0x18, 0x19, 0x1A and 0x1B load the RAM latch. Writes to 0x1C, 0x1D, 0x1E and 0x1F load the ROM latch. io_port[7:5] are ignored.
- R6: A window write with the ROM selected and rom_prog_en low asserts none of rom_cs, rom_we and ram_cs. With rom_prog_en high, the same write asserts rom_cs and rom_we at the mapped address.
- R7: An I/O read of any latch port drives io_rdata = 0xFF with io_rdata_oe = 1.
- R8: RAM latch bits 7:4 and ROM latch bits 6:5 are stored but do not alter phys_addr or the selects.
- R9: A latch write during a memory access leaves that access's phys_addr and selects unchanged. The new value applies from the next access.
- R10: ram_cs and rom_cs are never both 1. Either one is 1 only during a memory strobe with cpu_addr[15] = 0.
- R11: I/O writes to ports whose io_port[4:0] lies outside 0x18..0x1F change no latch. I/O reads of such ports keep io_rdata_oe = 0.
- R12: During a window access, phys_addr[14:0] equals cpu_addr[14:0].
- R13: ram_we is 1 exactly for a window write with RAM selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_port | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| io_rdata_oe | output | 1 | Data bus drive enable for I/O reads |
| mem_rd | input | 1 | Memory read strobe, held for the access |
| mem_wr | input | 1 | Memory write strobe, held for the access |
| cpu_addr | input | 16 | CPU memory address |
| rom_prog_en | input | 1 | Allows writes into the ROM |
| phys_addr | output | 20 | Physical memory address |
| ram_cs | output | 1 | RAM chip select |
| rom_cs | output | 1 | ROM chip select |
| ram_we | output | 1 | RAM write enable |
| rom_we | output | 1 | ROM write enable, gated by rom_prog_en |

## Verification
The bench builds the block with its default parameters: 4 RAM page bits, 5 ROM page bits, select at bit 7 and a 5-bit port decode. These values make every RAM page and every ROM page reachable within a short directed run. They also make all eight latch ports, in combination with set upper port bits, cheap to cover exhaustively. With them the tests can reach the alias and decode corners, the dropped ROM write, and a latch write that lands in the middle of a held access.

// File: rtl/bmw_pkg.sv
package bmw_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } acc_state_e;

    function automatic int bmw_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bmw_latch_regs.sv
module bmw_latch_regs #(
    parameter int DATA_W   = 8,
    parameter int PORT_W   = 8,
    parameter int DEC_W    = 5,
    parameter int ALIAS_W  = 2,
    parameter logic [DEC_W-1:0] RAM_BASE = 5'h18,
    parameter logic [DEC_W-1:0] ROM_BASE = 5'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [PORT_W-1:0] io_port,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] ram_latch,
    output logic [DATA_W-1:0] rom_latch,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rdata_oe
);
    localparam int N_LATCH = 2;
    localparam int TAG_W   = DEC_W - ALIAS_W;
    localparam logic [DEC_W-1:0] BASES [N_LATCH] = '{RAM_BASE, ROM_BASE};

    logic [N_LATCH-1:0]             hit;
    logic [N_LATCH-1:0][DATA_W-1:0] latch_q;
    logic [TAG_W-1:0]               port_tag;

    // Only the low DEC_W port bits take part in the decode; the alias bits are dropped too.
    assign port_tag = io_port[DEC_W-1:ALIAS_W];

    for (genvar g = 0; g < N_LATCH; g++) begin : g_latch
        assign hit[g] = (port_tag == BASES[g][DEC_W-1:ALIAS_W]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                latch_q[g] <= '0;
            else if (io_wr && hit[g])
                latch_q[g] <= io_wdata;
        end
    end

    assign ram_latch = latch_q[0];
    assign rom_latch = latch_q[1];

    // Write-only latches: a read returns all ones and drives the bus only when a latch port matches.
    always_comb begin
        io_rdata_oe = io_rd && (|hit);
        io_rdata    = io_rdata_oe ? '1 : '0;
    end

endmodule

// File: rtl/bmw_access_fsm.sv
module bmw_access_fsm
    import bmw_pkg::*;
#(
    parameter int PG_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mem_rd,
    input  logic            mem_wr,
    input  logic            live_sel,
    input  logic [PG_W-1:0] live_page,
    output logic            eff_sel,
    output logic [PG_W-1:0] eff_page
);
    acc_state_e      state_q, state_d;
    logic            snap_sel_q;
    logic [PG_W-1:0] snap_page_q;
    logic            strobe;

    assign strobe = mem_rd || mem_wr;

    // State register and capture of the mapping on the start transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            snap_sel_q  <= 1'b0;
            snap_page_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && strobe) begin
                snap_sel_q  <= live_sel;
                snap_page_q <= live_page;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d  = state_q;
        eff_sel  = live_sel;
        eff_page = live_page;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe)
                    state_d = ST_HOLD;       // start
            end
            ST_HOLD: begin
                eff_sel  = snap_sel_q;
                eff_page = snap_page_q;
                if (!strobe)
                    state_d = ST_IDLE;       // finish
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bmw_addr_map.sv
module bmw_addr_map #(
    parameter int CPU_AW = 16,
    parameter int OFS_W  = 15,
    parameter int PG_W   = 5
) (
    input  logic              eff_sel,
    input  logic [PG_W-1:0]   eff_page,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              rom_prog_en,
    output logic [PG_W+OFS_W-1:0] phys_addr,
    output logic              ram_cs,
    output logic              rom_cs,
    output logic              ram_we,
    output logic              rom_we
);
    logic in_win;
    logic rom_ok;

    assign in_win = !cpu_addr[CPU_AW-1] && (mem_rd || mem_wr);
    assign rom_ok = mem_rd || (mem_wr && rom_prog_en);

    always_comb begin
        phys_addr = {eff_page, cpu_addr[OFS_W-1:0]};
        ram_cs    = in_win && eff_sel;
        ram_we    = in_win && eff_sel && mem_wr;
        rom_cs    = in_win && !eff_sel && rom_ok;
        rom_we    = in_win && !eff_sel && mem_wr && rom_prog_en;
    end

endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
    import bmw_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PORT_W   = 8,
    parameter int CPU_AW   = 16,
    parameter int RAM_PG_W = 4,
    parameter int ROM_PG_W = 5,
    parameter int SEL_BIT  = 7,
    parameter int DEC_W    = 5,
    parameter int ALIAS_W  = 2,
    parameter logic [DEC_W-1:0] RAM_BASE = 5'h18,
    parameter logic [DEC_W-1:0] ROM_BASE = 5'h1C,
    localparam int OFS_W   = CPU_AW - 1,
    localparam int PG_W    = bmw_max(RAM_PG_W, ROM_PG_W),
    localparam int PHYS_AW = PG_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [PORT_W-1:0]  io_port,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [DATA_W-1:0]  io_rdata,
    output logic               io_rdata_oe,
    input  logic               mem_rd,
    input  logic               mem_wr,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               rom_prog_en,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               ram_cs,
    output logic               rom_cs,
    output logic               ram_we,
    output logic               rom_we
);
    logic [DATA_W-1:0] ram_latch, rom_latch;
    logic              live_sel, eff_sel;
    logic [PG_W-1:0]   live_page, eff_page;

    bmw_latch_regs #(
        .DATA_W(DATA_W), .PORT_W(PORT_W), .DEC_W(DEC_W), .ALIAS_W(ALIAS_W),
        .RAM_BASE(RAM_BASE), .ROM_BASE(ROM_BASE)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_port(io_port), .io_wdata(io_wdata),
        .ram_latch(ram_latch), .rom_latch(rom_latch),
        .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe)
    );

    // Live mapping: the select bit lives in the ROM latch; pages are zero-extended to PG_W.
    always_comb begin
        live_sel  = rom_latch[SEL_BIT];
        live_page = '0;
        if (live_sel)
            live_page[RAM_PG_W-1:0] = ram_latch[RAM_PG_W-1:0];
        else
            live_page[ROM_PG_W-1:0] = rom_latch[ROM_PG_W-1:0];
    end

    bmw_access_fsm #(.PG_W(PG_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .live_sel(live_sel), .live_page(live_page),
        .eff_sel(eff_sel), .eff_page(eff_page)
    );

    bmw_addr_map #(.CPU_AW(CPU_AW), .OFS_W(OFS_W), .PG_W(PG_W)) u_map (
        .eff_sel(eff_sel), .eff_page(eff_page), .cpu_addr(cpu_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .rom_prog_en(rom_prog_en),
        .phys_addr(phys_addr), .ram_cs(ram_cs), .rom_cs(rom_cs),
        .ram_we(ram_we), .rom_we(rom_we)
    );

endmodule

// File: rtl/bank_window_mapper_chk.sv
module bank_window_mapper_chk #(
    parameter int DATA_W  = 8,
    parameter int CPU_AW  = 16,
    parameter int PHYS_AW = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               io_wr,
    input logic               io_rd,
    input logic [DATA_W-1:0]  io_rdata,
    input logic               io_rdata_oe,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic [CPU_AW-1:0]  cpu_addr,
    input logic               rom_prog_en,
    input logic [PHYS_AW-1:0] phys_addr,
    input logic               ram_cs,
    input logic               rom_cs,
    input logic               ram_we,
    input logic               rom_we
);
    localparam int OFS_W = CPU_AW - 1;

    p_cs_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_cs && rom_cs));

    p_cs_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs || rom_cs) |-> (!cpu_addr[CPU_AW-1] && (mem_rd || mem_wr)));

    p_rom_we_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_we |-> (rom_prog_en && mem_wr && rom_cs));

    p_ram_we_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_cs && mem_wr));

    p_offset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs || rom_cs) |-> (phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]));

    p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> (io_rd && io_rdata == '1));

    p_hold_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && $past(mem_rd || mem_wr) && $stable(cpu_addr))
            |-> ($stable(phys_addr) && $stable(ram_cs)));

    p_no_oe_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_rd) |-> !io_rdata_oe);

endmodule

bind bank_window_mapper bank_window_mapper_chk #(
    .DATA_W(DATA_W), .CPU_AW(CPU_AW), .PHYS_AW(PHYS_AW)
) u_chk (.*);

// File: tb/bank_window_mapper_bench.sv
module bank_window_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_port = '0, io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rdata_oe;
    logic        mem_rd = 1'b0, mem_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        rom_prog_en = 1'b0;
    logic [19:0] phys_addr;
    logic        ram_cs, rom_cs, ram_we, rom_we;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] ram_m = 8'h00, rom_m = 8'h00;   // bench model of the latches

    always #5 clk = ~clk;

    bank_window_mapper u_bank_window_mapper (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] p, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_port = p; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        if (p[4:0] >= 5'h18 && p[4:0] <= 5'h1B) ram_m = d;
        else if (p[4:0] >= 5'h1C) rom_m = d;
    endtask

    function automatic logic [23:0] expect_bus(input logic wr, input logic [15:0] a);
        logic sel, win;
        logic [4:0] pg;
        sel = rom_m[7];
        win = !a[15];
        pg  = sel ? {1'b0, ram_m[3:0]} : rom_m[4:0];
        return {win && sel, win && !sel && (!wr || rom_prog_en),
                win && sel && wr, win && !sel && wr && rom_prog_en,
                win ? {pg, a[14:0]} : 20'h0};
    endfunction

    // One memory access: sample on its first cycle and on its held cycle.
    task automatic mem_check(input logic wr, input logic [15:0] a, input string req);
        logic [23:0] exp, act;
        @(negedge clk);
        mem_rd = !wr; mem_wr = wr; cpu_addr = a;
        #1;
        exp = expect_bus(wr, a);
        act = {ram_cs, rom_cs, ram_we, rom_we, a[15] ? 20'h0 : phys_addr};
        check(act == exp, req, "access", {8'h0, act}, {8'h0, exp});
        @(negedge clk);
        act = {ram_cs, rom_cs, ram_we, rom_we, a[15] ? 20'h0 : phys_addr};
        check(act == exp, req, "held access", {8'h0, act}, {8'h0, exp});
        mem_rd = 1'b0; mem_wr = 1'b0;
    endtask

    task automatic t_reset();   // R1
        mem_check(1'b0, 16'h1234, "R1");
        check(rom_m == 8'h00, "R1", "model", 0, 0);
    endtask

    task automatic t_rom_pages();   // R3, R12
        for (int p = 0; p < 32; p++) begin
            io_write(8'h1C, 8'(p));
            mem_check(1'b0, 16'(p * 977) & 16'h7FFF, "R3");
        end
        mem_check(1'b0, 16'h7FFF, "R12");
    endtask

    task automatic t_ram_pages();   // R2, R13
        io_write(8'h1C, 8'h80);
        for (int p = 0; p < 16; p++) begin
            io_write(8'h18, 8'(p));
            mem_check(1'b0, 16'h0ABC, "R2");
            mem_check(1'b1, 16'h4321, "R13");
        end
    endtask

    task automatic t_select();   // R4
        io_write(8'h18, 8'h85);
        io_write(8'h1C, 8'h03);
        mem_check(1'b0, 16'h0100, "R4");
        io_write(8'h1C, 8'h83);
        mem_check(1'b0, 16'h0100, "R4");
    endtask

    task automatic t_alias();   // R5
        for (int i = 0; i < 8; i++) begin
            for (int hi = 0; hi < 8; hi += 7) begin
                io_write({3'(hi), 5'h18 + 5'(i)}, 8'h80 | 8'(i * 3 + hi));
                mem_check(1'b0, 16'h0042, "R5");
            end
        end
    endtask

    task automatic t_prog();   // R6
        io_write(8'h1C, 8'h11);
        rom_prog_en = 1'b0;
        mem_check(1'b1, 16'h2000, "R6");
        rom_prog_en = 1'b1;
        mem_check(1'b1, 16'h2000, "R6");
        rom_prog_en = 1'b0;
    endtask

    task automatic t_readback();   // R7, R11
        for (int p = 0; p < 256; p += 5) begin
            logic hitp;
            hitp = (p[4:0] >= 5'h18);
            @(negedge clk);
            io_rd = 1'b1; io_port = 8'(p);
            #1;
            check(io_rdata_oe == hitp && (!hitp || io_rdata == 8'hFF),
                  hitp ? "R7" : "R11", "read", {23'h0, io_rdata_oe, io_rdata},
                  {23'h0, hitp, hitp ? 8'hFF : io_rdata});
            @(negedge clk);
            io_rd = 1'b0;
        end
    endtask

    task automatic t_unused();   // R8
        io_write(8'h1C, 8'h66);
        mem_check(1'b0, 16'h0777, "R8");
        io_write(8'h18, 8'hF9);
        io_write(8'h1C, 8'hE0);
        mem_check(1'b0, 16'h0777, "R8");
    endtask

    task automatic t_midaccess();   // R9
        logic [23:0] exp;
        io_write(8'h1C, 8'h05);
        exp = expect_bus(1'b0, 16'h0333);
        @(negedge clk);
        mem_rd = 1'b1; cpu_addr = 16'h0333;
        @(negedge clk);
        io_wr = 1'b1; io_port = 8'h1D; io_wdata = 8'h1A;
        @(negedge clk);
        io_wr = 1'b0;
        check({ram_cs, rom_cs, ram_we, rom_we, phys_addr} == exp, "R9", "held map",
              {8'h0, ram_cs, rom_cs, ram_we, rom_we, phys_addr}, {8'h0, exp});
        mem_rd = 1'b0;
        rom_m = 8'h1A;
        mem_check(1'b0, 16'h0333, "R9");
    endtask

    task automatic t_window();   // R10
        io_write(8'h1C, 8'h80);
        mem_check(1'b0, 16'h8123, "R10");
        io_write(8'h1C, 8'h00);
        mem_check(1'b1, 16'hFFFF, "R10");
        @(negedge clk);
        check(!ram_cs && !rom_cs, "R10", "idle selects", {30'h0, ram_cs, rom_cs}, 0);
    endtask

    task automatic t_other_ports();   // R11
        io_write(8'h1C, 8'h09);
        for (int p = 0; p < 24; p++) io_write(8'(p), 8'hA7);
        io_write(8'hF7, 8'hA7);
        mem_check(1'b0, 16'h0055, "R11");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rom_pages();
        t_ram_pages();
        t_select();
        t_alias();
        t_prog();
        t_readback();
        t_unused();
        t_midaccess();
        t_window();
        t_other_ports();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule